// File: doc/BRIEF.md
# Dual-Path Byte-Match Vectored Interrupt Unit

The unit watches two independent received byte streams, path 1 and path 2. Each stream delivers a byte together with a one-cycle valid strobe. Every path holds a match byte and a mask that the host programs. When a strobed byte agrees with the match byte on every bit whose mask bit is 0, the path's flag is set and the active-high interrupt request rises. The request stays high until the host clears the flags.

One vector register serves both paths. The host writes its upper six bits. Its two low bits are not storage: they follow the path flags, so each interrupting path, or both together, gives the host a different vector. While the interrupt acknowledge input is high, the vector is placed on the 8-bit read bus. A host that never acknowledges can still poll the flag registers. Reading a flag register clears that flag.

Top module: `vec_irq_unit`

## Requirements
- R1: After synchronous reset, every register reads 0, `irq` is low and `rdata_oe` is low.
- R2: A host write (`cs`=1, `wr`=1) stores `wdata` into the addressed match or mask register. The address map is 0 match 1, 1 mask 1, 3 match 2 and 4 mask 2. A host read (`cs`=1, `rd`=1) returns the addressed register on `rdata` in the same cycle, with `rdata_oe` high.
- R3: When path p strobes a byte (`rx_valid[p-1]`=1, path 1 on `rx_data[7:0]`, path 2 on `rx_data[15:8]`), the compare checks only the bits whose mask bit is 0. A mask bit of 1 makes that bit a don't-care. If every checked bit equals the match byte, the path flag reads 1 from the next cycle on.
- R4: A strobed byte that differs from the match byte on an unmasked bit leaves the flag unchanged. A byte presented without a strobe is never compared.
- R5: `irq` is high whenever either path flag is set, and it stays high until both flags are cleared.
- R6: Reading a flag register (address 2 for path 1, address 5 for path 2) returns {7'b0, flag} and clears that flag at the end of the read cycle. The flag's vector bit clears with it.
- R7: If a match and a flag-clearing read on the same path fall in the same cycle, the flag stays set.
- R8: The vector register is at address 6. A host write stores only `wdata[7:2]`, and writes to bits 1:0 have no effect. Vector bit 1 reads the path 2 flag and bit 0 reads the path 1 flag.
- R9: While `iack` is high, `rdata` carries the full vector and `rdata_oe` is high. This holds even if a register read happens in the same cycle.
- R10: When neither a read nor `iack` is active, `rdata_oe` is low and `rdata` is 0.
- R11: If both paths match in the same cycle, both flags set and vector bits 1:0 read 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Host select |
| wr | input | 1 | Host write strobe |
| rd | input | 1 | Host read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read / vector data |
| rdata_oe | output | 1 | High while rdata should be driven onto the bus |
| iack | input | 1 | Interrupt acknowledge |
| rx_valid | input | 2 | Per-path byte strobe (bit 0 path 1) |
| rx_data | input | 16 | Received bytes (7:0 path 1, 15:8 path 2) |
| irq | output | 1 | Interrupt request, active high |

## Verification
On every cycle, the assertions check the following:
- a strobed match sets the flag one cycle later, even against a simultaneous clear;
- a flag changes only on a match or a clear;
- a clear without a match drops the flag;
- `irq` cannot fall unless a clear happened;
- the vector's low bits on the bus mirror the flags during acknowledge;
- the bus is released when idle.

Only the bench scenarios can show the rest:
- that the mask really turns bits into don't-cares for chosen byte patterns;
- the register map and read-back values;
- that the vector's host bits survive while writes to its low bits are dropped;
- the end-to-end order of match, acknowledge and clear.

// File: rtl/vip_pkg.sv
package vip_pkg;
  localparam int NPATH = 2;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MATCH1 = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK1  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAG1  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MATCH2 = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASK2  = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAG2  = 3'd5;
  localparam logic [ADDR_W-1:0] A_VECT   = 3'd6;
  localparam int PATH_STRIDE = 3;
endpackage

// File: rtl/vip_path.sv
module vip_path
  import vip_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_byte,
  output logic [DW-1:0]     match_q,
  output logic [DW-1:0]     mask_q,
  output logic              flag_q,
  output logic              hit_ev,
  output logic              clr_ev
);
  localparam logic [ADDR_W-1:0] A_MATCH = BASE;
  localparam logic [ADDR_W-1:0] A_MASK  = BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FLAG  = BASE + ADDR_W'(2);

  function automatic logic masked_hit(input logic [DW-1:0] rx,
                                      input logic [DW-1:0] ref_b,
                                      input logic [DW-1:0] dont_care);
    logic [DW-1:0] diff;
    diff = (rx ^ ref_b) & ~dont_care;
    return diff == '0;
  endfunction

  assign hit_ev = rx_valid && masked_hit(rx_byte, match_q, mask_q);
  assign clr_ev = rd_en && (addr == A_FLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      mask_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_en && addr == A_MATCH) match_q <= wdata;
      if (wr_en && addr == A_MASK)  mask_q  <= wdata;
      if (hit_ev)      flag_q <= 1'b1;
      else if (clr_ev) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vip_vect.sv
module vip_vect
  import vip_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:NPATH] wdata_hi,
  input  logic [NPATH-1:0]  flags,
  output logic [DW-1:0]     vector
);
  logic [DW-1:NPATH] vhi_q;

  always_ff @(posedge clk) begin
    if (rst) vhi_q <= '0;
    else if (wr_en && addr == A_VECT) vhi_q <= wdata_hi;
  end

  assign vector = {vhi_q, flags};
endmodule

// File: rtl/vip_rdmux.sv
module vip_rdmux
  import vip_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                       rd_en,
  input  logic                       iack,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NPATH-1:0][DW-1:0]   match_q,
  input  logic [NPATH-1:0][DW-1:0]   mask_q,
  input  logic [NPATH-1:0]           flags,
  input  logic [DW-1:0]              vector,
  output logic [DW-1:0]              rdata,
  output logic                       rdata_oe
);
  logic [DW-1:0] reg_val;

  always_comb begin
    reg_val = '0;
    unique case (addr)
      A_MATCH1: reg_val = match_q[0];
      A_MASK1:  reg_val = mask_q[0];
      A_FLAG1:  reg_val = {{(DW-1){1'b0}}, flags[0]};
      A_MATCH2: reg_val = match_q[1];
      A_MASK2:  reg_val = mask_q[1];
      A_FLAG2:  reg_val = {{(DW-1){1'b0}}, flags[1]};
      A_VECT:   reg_val = vector;
      default:  reg_val = '0;
    endcase
  end

  always_comb begin
    rdata_oe = iack || rd_en;
    if (iack)       rdata = vector;
    else if (rd_en) rdata = reg_val;
    else            rdata = '0;
  end
endmodule

// File: rtl/vec_irq_unit.sv
module vec_irq_unit
  import vip_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rdata_oe,
  input  logic              iack,
  input  logic [NPATH-1:0]  rx_valid,
  input  logic [NPATH*DW-1:0] rx_data,
  output logic              irq
);
  logic wr_en, rd_en;
  logic [NPATH-1:0]         hit_ev, clr_ev, flag;
  logic [NPATH-1:0][DW-1:0] match_q, mask_q;
  logic [DW-1:0]            vector;

  assign wr_en = cs && wr;
  assign rd_en = cs && rd;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    vip_path #(
      .DW(DW),
      .BASE(ADDR_W'(p * PATH_STRIDE))
    ) u_path (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rx_valid(rx_valid[p]),
      .rx_byte(rx_data[p*DW +: DW]),
      .match_q(match_q[p]), .mask_q(mask_q[p]), .flag_q(flag[p]),
      .hit_ev(hit_ev[p]), .clr_ev(clr_ev[p])
    );
  end

  vip_vect #(.DW(DW)) u_vect (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata_hi(wdata[DW-1:NPATH]), .flags(flag), .vector(vector)
  );

  vip_rdmux #(.DW(DW)) u_rdmux (
    .rd_en(rd_en), .iack(iack), .addr(addr), .match_q(match_q),
    .mask_q(mask_q), .flags(flag), .vector(vector),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  assign irq = |flag;
endmodule

// File: rtl/vec_irq_unit_chk.sv
module vec_irq_unit_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs,
  input logic          rd,
  input logic          iack,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe,
  input logic          irq,
  input logic [1:0]    hit_ev,
  input logic [1:0]    clr_ev,
  input logic [1:0]    flag
);
  // R3 R7
  p1_hit_sets_chk: assert property (@(posedge clk) disable iff (rst)
    hit_ev[0] |=> flag[0]);
  // R3 R7
  p2_hit_sets_chk: assert property (@(posedge clk) disable iff (rst)
    hit_ev[1] |=> flag[1]);
  // R4
  p1_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit_ev[0] && !clr_ev[0]) |=> $stable(flag[0]));
  // R4
  p2_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit_ev[1] && !clr_ev[1]) |=> $stable(flag[1]));
  // R6
  p1_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ev[0] && !hit_ev[0]) |=> !flag[0]);
  // R6
  p2_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ev[1] && !hit_ev[1]) |=> !flag[1]);
  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && clr_ev == 2'b00) |=> irq);
  // R8 R9
  ack_vector_chk: assert property (@(posedge clk) disable iff (rst)
    iack |-> (rdata_oe && rdata[1:0] == flag));
  // R10
  bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!iack && !(cs && rd)) |-> (!rdata_oe && rdata == '0));
endmodule

bind vec_irq_unit vec_irq_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rd(rd), .iack(iack), .rdata(rdata),
  .rdata_oe(rdata_oe), .irq(irq), .hit_ev(hit_ev), .clr_ev(clr_ev),
  .flag(flag)
);

// File: tb/vec_irq_unit_test.sv
`timescale 1ns/1ps
module vec_irq_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 0, wr = 0, rd = 0, iack = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [1:0] rx_valid = 0;
  logic [15:0] rx_data = 0;
  logic [7:0] rdata;
  logic rdata_oe, irq;

  int total = 0;
  int bad = 0;

  typedef struct {
    bit         is_irq;
    logic       oe;
    logic [7:0] val;
    string      tag;
  } item_t;
  item_t sb[$];
  event samp;

  always #2.5 clk = ~clk;

  vec_irq_unit uut (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .iack(iack),
    .rx_valid(rx_valid), .rx_data(rx_data), .irq(irq)
  );

  localparam logic [2:0] M1 = 0, K1 = 1, F1 = 2, M2 = 3, K2 = 4, F2 = 5, VE = 6;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(samp);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        total++;
        if (it.is_irq) begin
          if (irq !== it.oe) begin
            bad++;
            $display("FAIL %s: irq actual=%b expected=%b", it.tag, irq, it.oe);
          end
        end else if (rdata_oe !== it.oe || rdata !== it.val) begin
          bad++;
          $display("FAIL %s: oe/rdata actual=%b/%02h expected=%b/%02h",
                   it.tag, rdata_oe, rdata, it.oe, it.val);
        end
      end
    end
  end

  task automatic drive(input logic c, input logic r, input logic w,
                       input logic [2:0] a, input logic [7:0] d,
                       input logic ack, input logic [1:0] v,
                       input logic [15:0] rx);
    @(negedge clk);
    cs = c; rd = r; wr = w; addr = a; wdata = d; iack = ack;
    rx_valid = v; rx_data = rx;
  endtask

  task automatic exp_bus(input logic oe, input logic [7:0] val, input string tag);
    sb.push_back('{1'b0, oe, val, tag});
    ->samp;
    #2;
  endtask

  task automatic exp_irq(input logic lvl, input string tag);
    sb.push_back('{1'b1, lvl, 8'h00, tag});
    ->samp;
    #2;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 2'b00, 16'h0);
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    drive(1, 0, 1, a, d, 0, 2'b00, 16'h0);
  endtask

  task automatic hread(input logic [2:0] a, input logic [7:0] e, input string tag);
    drive(1, 1, 0, a, 0, 0, 2'b00, 16'h0);
    exp_bus(1'b1, e, tag);
  endtask

  task automatic strobe(input logic [1:0] v, input logic [15:0] rx);
    drive(0, 0, 0, 0, 0, 0, v, rx);
  endtask

  task automatic ack(input logic [7:0] e, input string tag);
    drive(0, 0, 0, 0, 0, 1, 2'b00, 16'h0);
    exp_bus(1'b1, e, tag);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle();
    exp_bus(1'b0, 8'h00, "R1 R10 idle bus");
    exp_irq(1'b0, "R1 irq after reset");
    for (int a = 0; a < 7; a++) hread(3'(a), 8'h00, "R1 register zero");

    hwrite(M1, 8'hA5); hwrite(K1, 8'h00);
    hread(M1, 8'hA5, "R2 match1"); hread(K1, 8'h00, "R2 mask1");
    hwrite(M2, 8'h30); hwrite(K2, 8'h0F);
    hread(M2, 8'h30, "R2 match2"); hread(K2, 8'h0F, "R2 mask2");
    hwrite(VE, 8'hFF);
    hread(VE, 8'hFC, "R8 vector low bits not written");

    strobe(2'b01, 16'h00A4); idle();
    exp_irq(1'b0, "R4 mismatch no irq");
    hread(F1, 8'h00, "R4 mismatch flag1");
    strobe(2'b00, 16'h00A5); idle();
    exp_irq(1'b0, "R4 no strobe no compare");

    strobe(2'b01, 16'h00A5); idle();
    exp_irq(1'b1, "R3 R5 exact match irq");
    idle(); idle(); idle();
    exp_irq(1'b1, "R5 irq held");
    ack(8'hFD, "R9 R8 vector path1");
    hread(F1, 8'h01, "R6 flag1 read");
    idle();
    exp_irq(1'b0, "R6 irq after clear");
    hread(VE, 8'hFC, "R6 vector bit cleared");
    hread(F1, 8'h00, "R6 flag1 cleared");

    strobe(2'b10, 16'h3C00); idle();
    exp_irq(1'b1, "R3 masked match path2");
    ack(8'hFE, "R8 vector path2");
    drive(1, 1, 0, M1, 0, 1, 2'b00, 16'h0);
    exp_bus(1'b1, 8'hFE, "R9 ack over read");

    drive(1, 1, 0, F2, 0, 0, 2'b10, 16'h3500);
    exp_bus(1'b1, 8'h01, "R7 read during match");
    hread(F2, 8'h01, "R7 flag stays set");
    idle();
    exp_irq(1'b0, "R6 cleared path2");

    strobe(2'b10, 16'h7000); idle();
    hread(F2, 8'h00, "R4 unmasked bit differs");

    strobe(2'b11, 16'h30A5); idle();
    ack(8'hFF, "R11 both paths");
    hread(F1, 8'h01, "R11 flag1");
    hread(F2, 8'h01, "R11 flag2");
    idle();
    exp_irq(1'b0, "R5 irq low after both cleared");

    hwrite(K1, 8'hFF);
    strobe(2'b01, 16'h0012); idle();
    hread(F1, 8'h01, "R3 all bits masked");
    hwrite(VE, 8'h03);
    ack(8'h00, "R8 write to low bits ignored");
    idle();
    exp_bus(1'b0, 8'h00, "R10 bus released");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule